// File: doc/BRIEF.md
# Byte-Level Serial Bus Master Sequencer

This block runs the byte-by-byte flow of a serial-bus master transfer. Software sets a target address, a byte count and a control word. The sequencer then drives a separate bus engine through a per-byte valid/ready handshake. It issues an address phase, moves data bytes between a small byte buffer and the engine, and finishes with a stop or hands control back to software. Pin timing, slave operation and 10-bit addressing belong elsewhere.

There are two completion disciplines. In count mode a down-counter limits the transfer. What happens when the counter runs out depends on the stop bit. In repeat mode the counter is left alone: the sequencer keeps draining or filling the buffer until software asks for a stop. When the buffer is empty (transmit) or full (receive), the block stalls and raises a one-cycle ready event. It picks the transfer up again as soon as software pushes or pops a byte, or rewrites the control word.

Top module: `byte_bus_sequencer`

## Requirements
- R1: A control write stores the written word ANDed with 0xCF87, and `ctrlValue` shows it from the next cycle. Field positions: start bit 0, stop bit 1, repeat bit 2, extended-address bit 8, transmit bit 9, master bit 10, byte-order bit 14 (stored only), enable bit 15. An accepted start reads back with bit 0 cleared.
- R2: A control write with enable, master and start set and extended-address clear, made while idle or stalled, opens a transfer. `busy` rises, the buffer is emptied and `curCount` is loaded from the count register. A START operation (`opKind`=0) is then issued with `opAddr`=`slaveAddr` and `opRead` equal to NOT transmit. An operation held without `opReady` keeps its kind.
- R3: A start request with master clear, extended-address set or enable clear issues no operation and leaves `busy` low.
- R4: A START answered with `opAck`=0 pulses `nackEvt`, clears the stop bit, issues nothing more and drops `busy`.
- R5: Count-mode transmit sends buffer bytes oldest first as WRITE operations (`opKind`=1), decrementing `curCount` once per byte. An empty buffer with a nonzero count pulses `xrdyEvt` and stalls.
- R6: Count-mode receive issues READ operations (`opKind`=2), stores each `opRdByte` in the buffer and decrements `curCount`. A full buffer pulses `rrdyEvt` and stalls.
- R7: When the count reaches zero with stop clear, `ardyEvt` pulses, the master bit clears, `busy` drops and no STOP is issued. In receive mode with a nonempty buffer, `rrdyEvt` pulses in the same cycle as `ardyEvt`.
- R8: When the count reaches zero with stop set, a STOP operation (`opKind`=3) follows. Its handshake clears the stop bit, reloads `curCount` from the count register and drops `busy`. In transmit mode `ardyEvt` also pulses, master clears and the buffer is emptied. In receive mode `ardyEvt` does not pulse.
- R9: In repeat mode `curCount` is never changed by data bytes. Transmit drains the buffer and then pulses `xrdyEvt`. Receive fills the buffer to its depth and then pulses `rrdyEvt`. A set stop bit seen at an evaluation issues STOP.
- R10: A WRITE answered with `opAck`=0 pulses `nackEvt`, clears the stop bit, issues nothing more and drops `busy`.
- R11: A stalled transfer resumes after a software push, a software pop or a control write.
- R12: The buffer holds `BUF_DEPTH` bytes. `rxByte` shows the oldest byte. A push into a full buffer and a pop from an empty one are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word write value |
| cntWrEn | input | 1 | Count register write strobe |
| cntWrData | input | CNT_W | Count register write value |
| slaveAddr | input | ADDR_W | Target address for the address phase |
| txPush | input | 1 | Software pushes a byte into the buffer |
| txByte | input | 8 | Byte to push |
| rxPop | input | 1 | Software pops the oldest byte |
| rxByte | output | 8 | Oldest byte in the buffer |
| bufLevel | output | LVL_W | Bytes held in the buffer |
| ctrlValue | output | 16 | Stored control word |
| curCount | output | CNT_W | Current remaining byte count |
| busy | output | 1 | Transfer in progress |
| opValid | output | 1 | Operation request to the bus engine |
| opKind | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| opAddr | output | ADDR_W | Address for START |
| opRead | output | 1 | Direction for START, 1 = read |
| opByte | output | 8 | Byte for WRITE |
| opReady | input | 1 | Engine accepts the operation |
| opAck | input | 1 | Acknowledge result, valid with opReady |
| opRdByte | input | 8 | Received byte, valid with opReady on READ |
| nackEvt | output | 1 | One-cycle not-acknowledged event |
| ardyEvt | output | 1 | One-cycle access-ready event |
| rrdyEvt | output | 1 | One-cycle receive-ready event |
| xrdyEvt | output | 1 | One-cycle transmit-ready event |

## Verification
Count exhaustion in count-mode receive can raise the receive-ready and access-ready events in one cycle. The bench runs a three-byte receive with stop clear and leaves the bytes unread, so the buffer is nonempty when the count hits zero. The engine monitor counts the cycles where both events are high and expects exactly one. A second receive with stop set must show a receive-ready at the end but no access-ready.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'hCF87;

  localparam int BIT_START = 0;
  localparam int BIT_STOP  = 1;
  localparam int BIT_RPT   = 2;
  localparam int BIT_XADDR = 8;
  localparam int BIT_TX    = 9;
  localparam int BIT_MST   = 10;
  localparam int BIT_EN    = 15;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_EVAL,
    ST_SEND,
    ST_RECV,
    ST_STALL,
    ST_STOP
  } seqState_e;

  typedef struct packed {
    logic bufClear;
    logic engPush;
    logic engPop;
    logic cntLoad;
    logic cntDec;
    logic clrStart;
    logic clrStop;
    logic clrMst;
  } strobes_t;
endpackage

// File: rtl/bseq_fifo.sv
module bseq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          engPush,
  input  logic [W-1:0]  engData,
  input  logic          engPop,
  input  logic          swPush,
  input  logic [W-1:0]  swData,
  input  logic          swPop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          swPushOk,
  output logic          swPopOk
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic          pushEn, popEn;
  logic [W-1:0]  pushVal;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign swPushOk = swPush && !engPush && !full && !clear;
  assign swPopOk  = swPop && !engPop && !empty && !clear;
  assign pushEn   = !clear && (engPush || swPushOk);
  assign popEn    = !clear && (engPop || swPopOk);
  assign pushVal  = engPush ? engData : swData;
  assign head     = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (pushEn) wrPtr <= nextPtr(wrPtr);
      if (popEn)  rdPtr <= nextPtr(rdPtr);
      level <= level + LW'(pushEn) - LW'(popEn);
    end
  end

  assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));

  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    engPop |-> !empty);

  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    engPush |-> !full);
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUF_DEPTH = 4,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              txPush,
  input  logic [7:0]        txByte,
  input  logic              rxPop,
  input  logic [7:0]        engByte,
  input  strobes_t          str,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [CNT_W-1:0]  curCount,
  output logic              cntZero,
  output logic [7:0]        head,
  output logic [LVL_W-1:0]  level,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              bufTouched
);
  logic [CNT_W-1:0]  cntReg;
  logic [CTRL_W-1:0] ctrlNext;
  logic              swPushOk, swPopOk;

  always_comb begin
    ctrlNext = ctrlWrEn ? (ctrlWrData & CTRL_KEEP) : ctrlQ;
    if (str.clrStart) ctrlNext[BIT_START] = 1'b0;
    if (str.clrStop)  ctrlNext[BIT_STOP]  = 1'b0;
    if (str.clrMst)   ctrlNext[BIT_MST]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      cntReg   <= '0;
      curCount <= '0;
    end else begin
      ctrlQ <= ctrlNext;
      if (cntWrEn) cntReg <= cntWrData;
      if (str.cntLoad)     curCount <= cntReg;
      else if (str.cntDec) curCount <= curCount - CNT_W'(1);
    end
  end

  assign cntZero    = (curCount == '0);
  assign bufTouched = swPushOk || swPopOk;

  bseq_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (str.bufClear),
    .engPush  (str.engPush),
    .engData  (engByte),
    .engPop   (str.engPop),
    .swPush   (txPush),
    .swData   (txByte),
    .swPop    (rxPop),
    .head     (head),
    .level    (level),
    .empty    (bufEmpty),
    .full     (bufFull),
    .swPushOk (swPushOk),
    .swPopOk  (swPopOk)
  );

  assert_repeat_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_RPT] && !str.cntLoad) |=> $stable(curCount));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    str.clrStart |=> !ctrlQ[BIT_START]);

  assert_no_dec_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.cntDec |-> !cntZero);
endmodule

// File: rtl/bseq_control.sv
module bseq_control
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic [CTRL_W-1:0] ctrlQ,
  input  logic              cntZero,
  input  logic              bufEmpty,
  input  logic              bufFull,
  input  logic              bufTouched,
  input  logic [7:0]        head,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              opReady,
  input  logic              opAck,
  output strobes_t          str,
  output logic              opValid,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic              opRead,
  output logic [7:0]        opByte,
  output logic              busy,
  output logic              nackEvt,
  output logic              ardyEvt,
  output logic              rrdyEvt,
  output logic              xrdyEvt
);
  seqState_e state, stNext;
  logic startReq, hs;
  logic isTx, isRpt, isStop;
  logic nackN, ardyN, rrdyN, xrdyN;
  seqState_e moveState;
  logic moveX, moveR;

  assign isTx   = ctrlQ[BIT_TX];
  assign isRpt  = ctrlQ[BIT_RPT];
  assign isStop = ctrlQ[BIT_STOP];

  assign startReq = ctrlWrEn && ctrlWrData[BIT_EN] && ctrlWrData[BIT_MST] &&
                    ctrlWrData[BIT_START] && !ctrlWrData[BIT_XADDR] &&
                    (state == ST_IDLE || state == ST_STALL);
  assign hs     = opValid && opReady;
  assign busy   = (state != ST_IDLE);
  assign opAddr = slaveAddr;
  assign opRead = !isTx;
  assign opByte = head;

  // Data-movement choice shared by both modes once the count allows a byte.
  always_comb begin
    moveX = 1'b0;
    moveR = 1'b0;
    if (isTx) begin
      if (!bufEmpty) moveState = ST_SEND;
      else begin
        moveState = ST_STALL;
        moveX     = 1'b1;
      end
    end else begin
      if (!bufFull) moveState = ST_RECV;
      else begin
        moveState = ST_STALL;
        moveR     = 1'b1;
      end
    end
  end

  always_comb begin
    stNext  = state;
    str     = '0;
    opValid = 1'b0;
    opKind  = OP_START;
    nackN   = 1'b0;
    ardyN   = 1'b0;
    rrdyN   = 1'b0;
    xrdyN   = 1'b0;
    unique case (state)
      ST_IDLE, ST_STALL: begin
        if (startReq) begin
          stNext       = ST_ADDR;
          str.bufClear = 1'b1;
          str.cntLoad  = 1'b1;
          str.clrStart = 1'b1;
        end else if (state == ST_STALL && (bufTouched || ctrlWrEn)) begin
          stNext = ST_EVAL;
        end
      end
      ST_ADDR: begin
        opValid = 1'b1;
        opKind  = OP_START;
        if (hs) begin
          if (!opAck) begin
            nackN       = 1'b1;
            str.clrStop = 1'b1;
            stNext      = ST_IDLE;
          end else begin
            stNext = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (isRpt) begin
          if (isStop) stNext = ST_STOP;
          else begin
            stNext = moveState;
            xrdyN  = moveX;
            rrdyN  = moveR;
          end
        end else if (cntZero) begin
          if (isTx) begin
            ardyN      = 1'b1;
            str.clrMst = 1'b1;
          end else if (!bufEmpty) begin
            rrdyN = 1'b1;
          end
          if (isStop) stNext = ST_STOP;
          else begin
            stNext     = ST_IDLE;
            ardyN      = 1'b1;
            str.clrMst = 1'b1;
          end
        end else begin
          stNext = moveState;
          xrdyN  = moveX;
          rrdyN  = moveR;
        end
      end
      ST_SEND: begin
        opValid = 1'b1;
        opKind  = OP_WRITE;
        if (hs) begin
          str.engPop = 1'b1;
          str.cntDec = !isRpt;
          if (!opAck) begin
            nackN       = 1'b1;
            str.clrStop = 1'b1;
            stNext      = ST_IDLE;
          end else begin
            stNext = ST_EVAL;
          end
        end
      end
      ST_RECV: begin
        opValid = 1'b1;
        opKind  = OP_READ;
        if (hs) begin
          str.engPush = 1'b1;
          str.cntDec  = !isRpt;
          stNext      = ST_EVAL;
        end
      end
      ST_STOP: begin
        opValid = 1'b1;
        opKind  = OP_STOP;
        if (hs) begin
          str.clrStop  = 1'b1;
          str.cntLoad  = 1'b1;
          str.bufClear = isTx;
          stNext       = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nackEvt <= 1'b0;
      ardyEvt <= 1'b0;
      rrdyEvt <= 1'b0;
      xrdyEvt <= 1'b0;
    end else begin
      state   <= stNext;
      nackEvt <= nackN;
      ardyEvt <= ardyN;
      rrdyEvt <= rrdyN;
      xrdyEvt <= xrdyN;
    end
  end

  assert_op_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opReady) |=> (opValid && $stable(opKind)));

  assert_nack_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    nackEvt |-> !busy);

  assert_ardy_mst_R7: assert property (@(posedge clk) disable iff (!rstN)
    ardyEvt |-> !ctrlQ[BIT_MST]);

  assert_evt_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nackEvt, ardyEvt, xrdyEvt}));

  assert_nack_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    nackEvt |-> !ctrlQ[BIT_STOP]);
endmodule

// File: rtl/byte_bus_sequencer.sv
module byte_bus_sequencer
  import bseq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUF_DEPTH = 4,
  parameter int ADDR_W    = 10,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              txPush,
  input  logic [7:0]        txByte,
  input  logic              rxPop,
  output logic [7:0]        rxByte,
  output logic [LVL_W-1:0]  bufLevel,
  output logic [15:0]       ctrlValue,
  output logic [CNT_W-1:0]  curCount,
  output logic              busy,
  output logic              opValid,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic              opRead,
  output logic [7:0]        opByte,
  input  logic              opReady,
  input  logic              opAck,
  input  logic [7:0]        opRdByte,
  output logic              nackEvt,
  output logic              ardyEvt,
  output logic              rrdyEvt,
  output logic              xrdyEvt
);
  strobes_t   str;
  logic       cntZero, bufEmpty, bufFull, bufTouched;
  logic [7:0] head;

  assign rxByte = head;

  bseq_datapath #(.CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .cntWrEn    (cntWrEn),
    .cntWrData  (cntWrData),
    .txPush     (txPush),
    .txByte     (txByte),
    .rxPop      (rxPop),
    .engByte    (opRdByte),
    .str        (str),
    .ctrlQ      (ctrlValue),
    .curCount   (curCount),
    .cntZero    (cntZero),
    .head       (head),
    .level      (bufLevel),
    .bufEmpty   (bufEmpty),
    .bufFull    (bufFull),
    .bufTouched (bufTouched)
  );

  bseq_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .ctrlQ      (ctrlValue),
    .cntZero    (cntZero),
    .bufEmpty   (bufEmpty),
    .bufFull    (bufFull),
    .bufTouched (bufTouched),
    .head       (head),
    .slaveAddr  (slaveAddr),
    .opReady    (opReady),
    .opAck      (opAck),
    .str        (str),
    .opValid    (opValid),
    .opKind     (opKind),
    .opAddr     (opAddr),
    .opRead     (opRead),
    .opByte     (opByte),
    .busy       (busy),
    .nackEvt    (nackEvt),
    .ardyEvt    (ardyEvt),
    .rrdyEvt    (rrdyEvt),
    .xrdyEvt    (xrdyEvt)
  );
endmodule

// File: tb/sim_byte_bus_sequencer.sv
`timescale 1ns/1ps
module sim_byte_bus_sequencer;
  localparam int CNT_W = 16;
  localparam int DEPTH = 4;
  localparam int AW    = 10;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic cntWrEn = 1'b0;
  logic [CNT_W-1:0] cntWrData = '0;
  logic [AW-1:0] slaveAddr = 10'h05A;
  logic txPush = 1'b0;
  logic [7:0] txByte = '0;
  logic rxPop = 1'b0;
  logic [7:0] rxByte;
  logic [LW-1:0] bufLevel;
  logic [15:0] ctrlValue;
  logic [CNT_W-1:0] curCount;
  logic busy, opValid, opRead;
  logic [1:0] opKind;
  logic [AW-1:0] opAddr;
  logic [7:0] opByte;
  logic opReady = 1'b0;
  logic opAck = 1'b1;
  logic [7:0] opRdByte = '0;
  logic nackEvt, ardyEvt, rrdyEvt, xrdyEvt;

  always #2 clk = ~clk;

  byte_bus_sequencer #(.CNT_W(CNT_W), .BUF_DEPTH(DEPTH), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .slaveAddr(slaveAddr),
    .txPush(txPush), .txByte(txByte), .rxPop(rxPop), .rxByte(rxByte),
    .bufLevel(bufLevel), .ctrlValue(ctrlValue), .curCount(curCount),
    .busy(busy), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .opRead(opRead), .opByte(opByte), .opReady(opReady), .opAck(opAck),
    .opRdByte(opRdByte), .nackEvt(nackEvt), .ardyEvt(ardyEvt),
    .rrdyEvt(rrdyEvt), .xrdyEvt(xrdyEvt));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Engine model and event log
  logic [1:0] logKind [64];
  logic [7:0] logByte [64];
  logic       logRd   [64];
  int logN = 0, wrIdx = 0, rdIdx = 0, nackWr = -1;
  bit nackAddr = 0;
  int nackCnt = 0, ardyCnt = 0, rrdyCnt = 0, xrdyCnt = 0, bothCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (nackEvt) nackCnt++;
      if (ardyEvt) ardyCnt++;
      if (rrdyEvt) rrdyCnt++;
      if (xrdyEvt) xrdyCnt++;
      if (ardyEvt && rrdyEvt) bothCnt++;
      opReady = 1'b0;
      if (opValid && $urandom_range(0, 2) != 0) begin
        opReady = 1'b1;
        opAck = 1'b1;
        case (opKind)
          2'd0: opAck = !nackAddr;
          2'd1: begin opAck = (wrIdx != nackWr); wrIdx++; end
          2'd2: begin opRdByte = 8'hA0 + 8'(rdIdx); rdIdx++; end
          default: ;
        endcase
        if (logN < 64) begin
          logKind[logN] = opKind;
          logByte[logN] = (opKind == 2'd1) ? opByte :
                          (opKind == 2'd2) ? opRdByte : opAddr[7:0];
          logRd[logN]   = opRead;
        end
        logN++;
      end
    end
  end

  function automatic logic [15:0] cw(bit en, bit mst, bit tx, bit stp, bit rpt, bit stt);
    return {en, 1'b0, 3'b0, mst, tx, 1'b0, 5'b0, rpt, stp, stt};
  endfunction

  function automatic int kindCount(logic [1:0] k);
    int n = 0;
    for (int i = 0; i < logN && i < 64; i++) if (logKind[i] == k) n++;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(logic [15:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic wrCnt(logic [CNT_W-1:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    @(negedge clk);
    cntWrEn = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    int guard = 0;
    while (bufLevel == LW'(DEPTH) && guard < 2000) begin tick(1); guard++; end
    txPush = 1'b1; txByte = b;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popCheck(string tag, logic [7:0] exp);
    int guard = 0;
    while (bufLevel == '0 && guard < 2000) begin tick(1); guard++; end
    chk(tag, rxByte, exp);
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic waitIdle(string tag);
    int guard = 0;
    while (busy && guard < 3000) begin tick(1); guard++; end
    if (busy) chk(tag, 32'd1, 32'd0);
    tick(2);
  endtask

  task automatic waitFor(string tag, ref int cnt, input int target);
    int guard = 0;
    while (cnt < target && guard < 3000) begin tick(1); guard++; end
    chk(tag, 32'(cnt >= target), 32'd1);
  endtask

  task automatic clearLog();
    logN = 0; wrIdx = 0; rdIdx = 0; nackWr = -1; nackAddr = 0;
    nackCnt = 0; ardyCnt = 0; rrdyCnt = 0; xrdyCnt = 0; bothCnt = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] data [8];
    int n;
    void'($urandom(32'd20240611));
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 reset ctrl", ctrlValue, 0);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset opValid", opValid, 0);
    chk("R12 reset level", bufLevel, 0);

    // R12: buffer depth, order, ignored push/pop
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk("R12 full level", bufLevel, DEPTH);
    for (int i = 0; i < 4; i++) popCheck("R12 order", 8'h10 + 8'(i));
    rxPop = 1'b1; tick(1); rxPop = 1'b0;
    chk("R12 empty pop ignored", bufLevel, 0);

    // R1 / R3: masking and ignored starts
    clearLog();
    wrCtrl(16'hFFFF);
    chk("R1 mask", ctrlValue, 16'hCF87);
    wrCtrl(cw(1, 0, 1, 0, 0, 1));
    tick(8);
    wrCtrl(cw(0, 1, 1, 0, 0, 1));
    tick(8);
    chk("R3 no op issued", logN, 0);
    chk("R3 busy low", busy, 0);

    // R4: address not acknowledged
    clearLog();
    wrCnt(3);
    nackAddr = 1;
    wrCtrl(cw(1, 1, 1, 1, 0, 1));
    chk("R1 start self clear", ctrlValue[0], 0);
    waitIdle("R4 idle timeout");
    chk("R2 start op kind", logKind[0], 0);
    chk("R2 start addr", logByte[0], 8'h5A);
    chk("R2 start dir", logRd[0], 0);
    chk("R4 only address op", logN, 1);
    chk("R4 nack event", nackCnt, 1);
    chk("R4 stop cleared", ctrlValue[1], 0);

    // R5 R7 R11: count-mode transmit with stall, stop clear
    clearLog();
    wrCnt(6);
    wrCtrl(cw(1, 1, 1, 0, 0, 1));
    for (int i = 0; i < 6; i++) data[i] = 8'($urandom);
    push(data[0]); push(data[1]);
    begin int guard = 0; while (kindCount(1) < 2 && guard < 2000) begin tick(1); guard++; end end
    tick(4);
    chk("R5 stalled busy", busy, 1);
    chk("R5 count after two", curCount, 4);
    chk("R5 xrdy on empty", 32'(xrdyCnt >= 1), 1);
    for (int i = 2; i < 6; i++) push(data[i]);
    waitIdle("R11 idle timeout");
    chk("R11 resumed writes", kindCount(1), 6);
    for (int i = 0; i < 6; i++) chk("R5 byte order", logByte[i + 1], data[i]);
    chk("R7 no stop op", kindCount(3), 0);
    chk("R7 ardy", ardyCnt, 1);
    chk("R7 master cleared", ctrlValue[10], 0);
    chk("R7 count zero", curCount, 0);

    // R7 R6: count-mode receive, three bytes, stop clear: ardy and rrdy together
    clearLog();
    wrCnt(3);
    wrCtrl(cw(1, 1, 0, 0, 0, 1));
    waitIdle("R6 idle timeout");
    chk("R2 read direction", logRd[0], 1);
    chk("R6 reads", kindCount(2), 3);
    chk("R7 ardy rx", ardyCnt, 1);
    chk("R7 rrdy with ardy", bothCnt, 1);
    for (int i = 0; i < 3; i++) popCheck("R6 rx data", 8'hA0 + 8'(i));

    // R6 R8 R11: count-mode receive, six bytes, stop set
    clearLog();
    wrCnt(6);
    wrCtrl(cw(1, 1, 0, 1, 0, 1));
    waitFor("R6 full stall", rrdyCnt, 1);
    tick(3);
    chk("R6 stall busy", busy, 1);
    chk("R6 stall level", bufLevel, DEPTH);
    chk("R6 stall count", curCount, 2);
    for (int i = 0; i < 4; i++) popCheck("R11 rx data", 8'hA0 + 8'(i));
    waitIdle("R8 idle timeout");
    chk("R8 reads", kindCount(2), 6);
    chk("R8 stop op", kindCount(3), 1);
    chk("R8 no ardy rx", ardyCnt, 0);
    chk("R8 rrdy twice", rrdyCnt, 2);
    chk("R8 count reload", curCount, 6);
    chk("R8 stop cleared", ctrlValue[1], 0);
    chk("R8 master kept rx", ctrlValue[10], 1);
    chk("R8 rx buffer kept", bufLevel, 2);
    popCheck("R8 rx tail", 8'hA4);
    popCheck("R8 rx tail", 8'hA5);

    // R9: repeat-mode transmit, count untouched, stop by control write
    clearLog();
    wrCnt(1);
    wrCtrl(cw(1, 1, 1, 0, 1, 1));
    for (int i = 0; i < 5; i++) begin data[i] = 8'($urandom); push(data[i]); end
    begin int guard = 0; while (kindCount(1) < 5 && guard < 2000) begin tick(1); guard++; end end
    tick(4);
    chk("R9 busy while waiting", busy, 1);
    chk("R9 count untouched", curCount, 1);
    wrCtrl(cw(1, 1, 1, 1, 1, 0));
    waitIdle("R9 idle timeout");
    chk("R9 writes", kindCount(1), 5);
    for (int i = 0; i < 5; i++) chk("R9 byte order", logByte[i + 1], data[i]);
    chk("R9 stop op last", logKind[6], 3);
    chk("R9 stop cleared", ctrlValue[1], 0);

    // R9: repeat-mode receive fills to depth
    clearLog();
    wrCnt(2);
    wrCtrl(cw(1, 1, 0, 0, 1, 1));
    waitFor("R9 rx full", rrdyCnt, 1);
    tick(3);
    chk("R9 rx reads", kindCount(2), DEPTH);
    chk("R9 rx count", curCount, 2);
    wrCtrl(cw(1, 1, 0, 1, 1, 0));
    waitIdle("R9 rx idle timeout");
    chk("R9 rx stop", kindCount(3), 1);
    chk("R9 rx level", bufLevel, DEPTH);

    // R10: data byte not acknowledged
    clearLog();
    wrCnt(4);
    nackWr = 1;
    wrCtrl(cw(1, 1, 1, 1, 0, 1));
    push(8'h31); push(8'h32); push(8'h33);
    waitIdle("R10 idle timeout");
    chk("R10 ops", logN, 3);
    chk("R10 nack", nackCnt, 1);
    chk("R10 stop cleared", ctrlValue[1], 0);
    chk("R10 level", bufLevel, 1);
    chk("R10 count", curCount, 2);

    // R8: random count-mode transmits with stop
    for (int it = 0; it < 6; it++) begin
      clearLog();
      n = $urandom_range(1, 4);
      wrCnt(CNT_W'(n));
      wrCtrl(cw(1, 1, 1, 1, 0, 1));
      for (int i = 0; i < n; i++) begin data[i] = 8'($urandom); push(data[i]); end
      waitIdle("R8 rand idle timeout");
      chk("R8 rand writes", kindCount(1), n);
      for (int i = 0; i < n; i++) chk("R8 rand bytes", logByte[i + 1], data[i]);
      chk("R8 rand stop last", logKind[n + 1], 3);
      chk("R8 rand reload", curCount, n);
      chk("R8 rand ardy", ardyCnt, 1);
      chk("R8 rand master", ctrlValue[10], 0);
      chk("R8 rand buffer", bufLevel, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule